// File: doc/BRIEF.md
# Double-buffered DAC input register interface

This block is the bus-side register set of a 14-bit multiplying digital-to-analog converter. A processor writes to it with an ordinary memory-write cycle: an active-low chip select and an active-low write strobe, two address select lines, and a data bus of up to 14 bits. Behind the bus sit an 8-bit low-byte buffer, a 6-bit high-byte buffer and a 14-bit DAC register whose contents drive the converter switches.

On a narrow bus the processor loads the two byte buffers one at a time and then issues a transfer that moves both into the DAC register at once, so the converter never sees a half-updated code. On a wide bus a single direct write loads all three registers together; while that write is held, the path is transparent and the data pins drive the DAC output directly. The strobes are sampled in a synchronous clock domain, and a write takes effect on the cycle in which the combined enable (both strobes low) ends, whichever strobe rises first.

Top module: `dac_word_loader`

## Requirements
- R1: After reset the DAC output and both byte buffers are zero; a transfer issued straight after reset leaves the output at zero.
- R2: A write happens only while both `cs_n` and `wr_n` are low; strobing only one of them loads no register, so neither the output nor a later transfer shows the data that was on the pins.
- R3: Select code `{sel[1],sel[0]} = 2'b10` loads `bus_data[7:0]` into the low buffer when the write ends; the DAC output does not change.
- R4: Select code `2'b01` loads `bus_data[13:8]` into the high buffer when the write ends; the DAC output does not change.
- R5: Select code `2'b11` loads the DAC register with the high buffer in bits 13:8 and the low buffer in bits 7:0; the data pins are ignored. The new word appears on the output in the clock cycle in which the enable ends.
- R6: Select code `2'b00` makes all registers transparent: while both strobes are low the output equals `bus_data` in the same cycle, and after release the output and both buffers hold the last value sampled while enabled.
- R7: A write commits the address and data sampled on the last clock edge at which both strobes were low; values changed in the release cycle are ignored, and the write ends equally when `cs_n` or when `wr_n` rises first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 14 | Data bus; bits 7:0 low byte, bits 13:8 high byte |
| sel | input | 2 | Operation select; sel[0] and sel[1] are the two address lines |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| dac_word | output | 14 | Word driving the converter switches |

## Verification
The bench walks byte loads in both orders and samples the output after each one, so a design that let a byte load leak into the DAC register would show a half-updated code before the transfer. It puts junk on the pins during a transfer and during strobe release, so a design that read live pins at the committing edge instead of the last enabled sample would commit the wrong word. Half-strobed writes with only one of the two strobes low would expose a design that decoded either strobe alone, and a direct write changed mid-window would expose a design that latched once instead of staying transparent, or forgot to refresh the buffers behind the output.

// File: rtl/dac_word_pkg.sv
package dac_word_pkg;

  // Operation codes, indexed as {sel[1], sel[0]}.
  typedef enum logic [1:0] {
    OP_DIRECT = 2'b00,
    OP_HIGH   = 2'b01,
    OP_LOW    = 2'b10,
    OP_XFER   = 2'b11
  } op_t;

  function automatic op_t pick_op(input logic [1:0] sel);
    return op_t'(sel);
  endfunction

  // Combined active-low enable: a write window is open only with both low.
  function automatic logic window_open(input logic cs_n, input logic wr_n);
    return !cs_n && !wr_n;
  endfunction

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] data,
  output logic              strobe_on,
  output logic              commit_ev,
  output logic [1:0]        cap_sel,
  output logic [DATA_W-1:0] cap_data
);
  import dac_word_pkg::*;

  logic on_q;

  assign strobe_on = rst_n && window_open(cs_n, wr_n);
  // End of the write window: open last cycle, closed now.
  assign commit_ev = on_q && !strobe_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      cap_sel  <= '0;
      cap_data <= '0;
    end else begin
      on_q <= strobe_on;
      if (strobe_on) begin
        cap_sel  <= sel;
        cap_data <= data;
      end
    end
  end

endmodule

// File: rtl/byte_buffers.sv
module byte_buffers #(
  parameter int LO_W = 8,
  parameter int HI_W = 6,
  localparam int WORD_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [WORD_W-1:0] din,
  output logic [LO_W-1:0]   lo_buf,
  output logic [HI_W-1:0]   hi_buf
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_buf <= '0;
    end else if (ld_lo) begin
      lo_buf <= din[LO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_buf <= '0;
    end else if (ld_hi) begin
      hi_buf <= din[WORD_W-1:LO_W];
    end
  end

endmodule

// File: rtl/dac_hold.sv
module dac_hold #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] din,
  input  logic              bypass,
  input  logic [WORD_W-1:0] bypass_data,
  output logic [WORD_W-1:0] dac_q,
  output logic [WORD_W-1:0] dac_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0;
    end else if (ld) begin
      dac_q <= din;
    end
  end

  assign dac_word = bypass ? bypass_data : dac_q;

endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader #(
  parameter int LO_W = 8,
  parameter int HI_W = 6,
  localparam int WORD_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_data,
  input  logic [1:0]        sel,
  input  logic              cs_n,
  input  logic              wr_n,
  output logic [WORD_W-1:0] dac_word
);
  import dac_word_pkg::*;

  logic              strobe_on;
  logic              commit_ev;
  logic [1:0]        cap_sel;
  logic [WORD_W-1:0] cap_data;
  logic [LO_W-1:0]   lo_buf;
  logic [HI_W-1:0]   hi_buf;
  logic [WORD_W-1:0] dac_q;
  op_t               live_op;
  op_t               cmd;
  logic              direct_live;
  logic              ld_lo;
  logic              ld_hi;
  logic              ld_dac;
  logic [WORD_W-1:0] buf_din;
  logic [WORD_W-1:0] dac_din;

  strobe_capture #(.DATA_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .sel       (sel),
    .data      (bus_data),
    .strobe_on (strobe_on),
    .commit_ev (commit_ev),
    .cap_sel   (cap_sel),
    .cap_data  (cap_data)
  );

  assign live_op     = pick_op(sel);
  assign cmd         = pick_op(cap_sel);
  // Transparent window: direct code with the write window open.
  assign direct_live = strobe_on && (live_op == OP_DIRECT);

  always_comb begin
    ld_lo   = direct_live;
    ld_hi   = direct_live;
    ld_dac  = direct_live;
    buf_din = direct_live ? bus_data : cap_data;
    dac_din = direct_live ? bus_data : cap_data;
    if (commit_ev) begin
      unique case (cmd)
        OP_DIRECT: begin
          ld_lo  = 1'b1;
          ld_hi  = 1'b1;
          ld_dac = 1'b1;
        end
        OP_LOW:  ld_lo = 1'b1;
        OP_HIGH: ld_hi = 1'b1;
        OP_XFER: begin
          ld_dac  = 1'b1;
          dac_din = {hi_buf, lo_buf};
        end
      endcase
    end
  end

  byte_buffers #(.LO_W(LO_W), .HI_W(HI_W)) u_bufs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi),
    .din    (buf_din),
    .lo_buf (lo_buf),
    .hi_buf (hi_buf)
  );

  dac_hold #(.WORD_W(WORD_W)) u_dac (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld          (ld_dac),
    .din         (dac_din),
    .bypass      (direct_live),
    .bypass_data (bus_data),
    .dac_q       (dac_q),
    .dac_word    (dac_word)
  );

endmodule

// File: rtl/dac_word_loader_chk.sv
module dac_word_loader_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 6,
  localparam int WORD_W = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] bus_data,
  input logic [WORD_W-1:0] dac_word,
  input logic              commit_ev,
  input logic              direct_live,
  input logic [1:0]        cap_sel,
  input logic [WORD_W-1:0] cap_data,
  input logic [LO_W-1:0]   lo_buf,
  input logic [HI_W-1:0]   hi_buf,
  input logic [WORD_W-1:0] dac_q
);
  import dac_word_pkg::*;

  // R1: held reset keeps the output and buffers at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (dac_word == '0 && lo_buf == '0 && hi_buf == '0));

  // R2: without a commit or transparent window the DAC register holds
  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev || direct_live) |=> $stable(dac_q));

  // R3: low-byte commit fills the low buffer and leaves the DAC register
  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && cap_sel == OP_LOW) |=>
      ($stable(dac_q) && $stable(hi_buf) && lo_buf == $past(cap_data[LO_W-1:0])));

  // R4: high-byte commit fills the high buffer and leaves the DAC register
  assert_high_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && cap_sel == OP_HIGH) |=>
      ($stable(dac_q) && $stable(lo_buf) && hi_buf == $past(cap_data[WORD_W-1:LO_W])));

  // R5: transfer joins the two buffers into the DAC register
  assert_xfer_join_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && cap_sel == OP_XFER) |=> (dac_q == {$past(hi_buf), $past(lo_buf)}));

  // R6: transparent window drives the pins straight to the output
  assert_direct_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    direct_live |-> (dac_word == bus_data));

endmodule

bind dac_word_loader dac_word_loader_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_data    (bus_data),
  .dac_word    (dac_word),
  .commit_ev   (commit_ev),
  .direct_live (direct_live),
  .cap_sel     (cap_sel),
  .cap_data    (cap_data),
  .lo_buf      (lo_buf),
  .hi_buf      (hi_buf),
  .dac_q       (dac_q)
);

// File: tb/dac_word_loader_test.sv
module dac_word_loader_test;

  localparam int LO_W = 8;
  localparam int HI_W = 6;
  localparam int W    = LO_W + HI_W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] bus_data;
  logic [1:0]   sel;
  logic         cs_n;
  logic         wr_n;
  logic [W-1:0] dac_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model of the registers, built from the requirements.
  logic [LO_W-1:0] m_lo;
  logic [HI_W-1:0] m_hi;
  logic [W-1:0]    m_dac;

  always #2.5 clk = ~clk;

  dac_word_loader #(.LO_W(LO_W), .HI_W(HI_W)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_data (bus_data),
    .sel      (sel),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .dac_word (dac_word)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Open a write window, hold it, release by wr_n (or cs_n), then wait for
  // the commit edge and return at the following negedge.
  task automatic bus_write(input logic [1:0] s, input logic [W-1:0] d,
                           input int hold, input bit cs_first);
    @(negedge clk);
    sel = s; bus_data = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
    sel = ~s; bus_data = ~d;          // release-cycle junk must be ignored
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 output zero after reset", dac_word, '0);
    bus_write(2'b11, 14'h3FFF, 2, 1'b0);
    check("R1 transfer after reset gives zero", dac_word, '0);
  endtask

  task automatic t_byte_loads;
    bus_write(2'b10, 14'h12A5, 2, 1'b0);
    m_lo = 8'hA5;
    check("R3 output unchanged after low load", dac_word, m_dac);
    bus_write(2'b01, 14'h2C00 | 14'h00FF, 3, 1'b0);
    m_hi = 6'h2C;
    check("R4 output unchanged after high load", dac_word, m_dac);
    bus_write(2'b11, 14'h0F0F, 1, 1'b0);
    m_dac = {m_hi, m_lo};
    check("R5 transfer joins buffers", dac_word, m_dac);
    // Reverse order: high first, then low.
    bus_write(2'b01, 14'h0700, 1, 1'b0);
    m_hi = 6'h07;
    check("R4 output unchanged, high first", dac_word, m_dac);
    bus_write(2'b10, 14'h003C, 1, 1'b0);
    m_lo = 8'h3C;
    check("R3 output unchanged, low second", dac_word, m_dac);
    bus_write(2'b11, 14'h1234, 2, 1'b1);
    m_dac = {m_hi, m_lo};
    check("R5 transfer ignores pins", dac_word, m_dac);
  endtask

  task automatic t_half_strobe;
    @(negedge clk);
    sel = 2'b00; bus_data = 14'h1111; cs_n = 1'b0; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 cs_n alone does not load", dac_word, m_dac);
    cs_n = 1'b1;
    @(negedge clk);
    sel = 2'b01; bus_data = 14'h3F00; cs_n = 1'b1; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    sel = 2'b10; bus_data = 14'h00EE; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 wr_n alone does not load", dac_word, m_dac);
    bus_write(2'b11, 14'h0000, 1, 1'b0);
    check("R2 buffers untouched by half strobes", dac_word, m_dac);
  endtask

  task automatic t_direct;
    @(negedge clk);
    sel = 2'b00; bus_data = 14'h2468; cs_n = 1'b0; wr_n = 1'b0;
    #1;
    check("R6 transparent same cycle", dac_word, 14'h2468);
    @(negedge clk);
    bus_data = 14'h1357;
    #1;
    check("R6 transparent follows pins", dac_word, 14'h1357);
    @(negedge clk);
    wr_n = 1'b1; bus_data = 14'h3FFF; sel = 2'b11;
    #1;
    check("R6 holds last sample on release", dac_word, 14'h1357);
    @(negedge clk);
    cs_n = 1'b1;
    m_dac = 14'h1357; m_lo = 8'h57; m_hi = 6'h13;
    check("R6 held after commit", dac_word, m_dac);
    bus_write(2'b10, 14'h0000, 1, 1'b0);
    m_lo = 8'h00;
    bus_write(2'b11, 14'h0000, 1, 1'b0);
    m_dac = {m_hi, m_lo};
    check("R6 high buffer loaded by direct write", dac_word, m_dac);
    bus_write(2'b00, 14'h3FFF, 2, 1'b1);
    m_dac = 14'h3FFF; m_lo = 8'hFF; m_hi = 6'h3F;
    check("R7 direct ended by cs_n, all ones", dac_word, m_dac);
    bus_write(2'b00, 14'h0000, 1, 1'b0);
    m_dac = '0; m_lo = '0; m_hi = '0;
    check("R6 direct all zeros", dac_word, m_dac);
  endtask

  task automatic t_last_sample;
    @(negedge clk);
    sel = 2'b10; bus_data = 14'h0011; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    bus_data = 14'h0077;
    @(negedge clk);
    cs_n = 1'b1; sel = 2'b11; bus_data = 14'h00FF;
    @(negedge clk);
    wr_n = 1'b1;
    m_lo = 8'h77;
    check("R7 low load leaves output", dac_word, m_dac);
    bus_write(2'b11, 14'h2222, 1, 1'b0);
    m_dac = {m_hi, m_lo};
    check("R7 last enabled sample committed", dac_word, m_dac);
  endtask

  initial begin
    rst_n = 1'b0; bus_data = '0; sel = 2'b00; cs_n = 1'b1; wr_n = 1'b1;
    m_lo = '0; m_hi = '0; m_dac = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_loads();
    t_half_strobe();
    t_direct();
    t_last_sample();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule